// File: doc/BRIEF.md
# Firmware flash write-enable control register

This block is an 8-bit control register that sits on a host register bus and decides whether write cycles to the firmware flash may proceed. Software enables flash writes by setting a write-enable bit. A lock bit can also be set, and once set it stays set until reset. While the lock is set, software can still set the write-enable bit. That write is not blocked: it takes effect, and the register then raises a one-cycle system-management interrupt request. The request lets management-mode firmware inspect the register and clear the write-enable bit again.

An optional SMM-only protect bit narrows the permission further. When this bit is set, flash writes are allowed only while every processor reports that it is in system management mode. A build parameter can remove this feature. When it is removed, the upper three bits are reserved: they read as zero and writes to them do nothing.

The flash-write-permitted output is combinational from the register state and the per-processor status. The interrupt request is registered and appears in the cycle after the write edge that caused it.

Top module: `bios_wr_ctrl`

## Requirements
- R1: After reset the readback is 0x00, the interrupt request is low and flash writes are not permitted.
- R2: Bit 0 (write enable) takes the written value on every write, whether or not the lock bit is set, and the readback shows the new value in the cycle after the write edge.
- R3: Bit 1 (lock) is set by writing 1 to it. Writing 0 does not clear it; only reset clears it.
- R4: A write with bit 0 = 1, made while bit 0 currently reads 0 and the lock is either already set or set by the same write, drives smi_req_o high for exactly the one cycle after the write edge.
- R5: No interrupt request is made when the lock is clear, when bit 0 already reads 1, or when the write has bit 0 = 0.
- R6: When bit 5 reads 0, flash_wr_ok_o equals bit 0 of the register.
- R7: When bit 5 (SMM-only protect) reads 1, flash_wr_ok_o is 1 only if bit 0 is 1 and every bit of cpu_in_smm_i is 1.
- R8: Bits 4:2 are plain read/write storage with no effect on permission. Bits 7:6 always read 0 and ignore writes.
- R9: With HAS_SMM_BWP = 0, bits 7:5 read 0 and ignore writes, and flash_wr_ok_o equals bit 0 regardless of cpu_in_smm_i.
- R10: After the interrupt request, a write of 0 to bit 0 (a handler reverting it) makes flash_wr_ok_o drop to 0 while the lock stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per high cycle |
| wr_data_i | input | 8 | Write data |
| cpu_in_smm_i | input | NUM_CPUS | Per-processor in-management-mode status |
| rd_data_o | output | 8 | Current register value |
| smi_req_o | output | 1 | One-cycle management interrupt request |
| flash_wr_ok_o | output | 1 | Flash write cycles permitted |

## Verification
The assertions assume that wr_en_i and wr_data_i change only away from the rising clock edge and are never unknown outside reset. They also assume that a write is a single-cycle strobe, with the readback of the previous cycle giving the state that the write is judged against. The bench drives all inputs on the falling edge, holds the strobe for one cycle and then returns it low. It changes cpu_in_smm_i only together with a write or during idle cycles. This means each interrupt pulse is followed by an idle cycle in which the pulse must have ended.

// File: rtl/bios_wr_ctrl_pkg.sv
package bios_wr_ctrl_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned WE_BIT   = 0;
  localparam int unsigned LOCK_BIT = 1;
  localparam int unsigned SCR_LO   = 2;
  localparam int unsigned SCR_HI   = 4;
  localparam int unsigned SCR_W    = SCR_HI - SCR_LO + 1;
  localparam int unsigned BWP_BIT  = 5;

  typedef struct packed {
    logic             bwp;
    logic [SCR_W-1:0] scr;
    logic             lock;
    logic             we;
  } ctl_state_t;
endpackage

// File: rtl/bios_wr_ctrl_regs.sv
module bios_wr_ctrl_regs
  import bios_wr_ctrl_pkg::*;
#(
  parameter bit HAS_SMM_BWP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctl_state_t       state_o
);
  logic             we_q, lock_q;
  logic [SCR_W-1:0] scr_q;
  logic             unused_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      lock_q <= 1'b0;
      scr_q  <= '0;
    end else if (wr_en_i) begin
      we_q   <= wr_data_i[WE_BIT];
      lock_q <= lock_q | wr_data_i[LOCK_BIT];  // sticky until reset
      scr_q  <= wr_data_i[SCR_HI:SCR_LO];
    end
  end

  generate
    if (HAS_SMM_BWP) begin : g_bwp
      logic bwp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      bwp_q <= 1'b0;
        else if (wr_en_i) bwp_q <= wr_data_i[BWP_BIT];
      end
      assign state_o.bwp = bwp_q;
      assign unused_wr   = ^wr_data_i[REG_W-1:BWP_BIT+1];
    end else begin : g_no_bwp
      assign state_o.bwp = 1'b0;
      assign unused_wr   = ^wr_data_i[REG_W-1:BWP_BIT];
    end
  endgenerate

  assign state_o.we   = we_q;
  assign state_o.lock = lock_q;
  assign state_o.scr  = scr_q;
endmodule

// File: rtl/bios_wr_ctrl_trigger.sv
module bios_wr_ctrl_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_we_i,
  input  logic wr_lock_i,
  input  logic we_q_i,
  input  logic lock_q_i,
  output logic smi_o
);
  logic rise_under_lock;

  // 0->1 of write enable while lock is held or being set in the same write
  assign rise_under_lock = wr_en_i & wr_we_i & ~we_q_i & (lock_q_i | wr_lock_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_o <= 1'b0;
    else         smi_o <= rise_under_lock;
  end
endmodule

// File: rtl/bios_wr_ctrl_permit.sv
module bios_wr_ctrl_permit #(
  parameter int unsigned NUM_CPUS    = 4,
  parameter bit          HAS_SMM_BWP = 1'b1
) (
  input  logic                we_i,
  input  logic                bwp_i,
  input  logic [NUM_CPUS-1:0] cpu_in_smm_i,
  output logic                ok_o
);
  generate
    if (HAS_SMM_BWP) begin : g_bwp
      logic all_smm;
      assign all_smm = &cpu_in_smm_i;
      assign ok_o    = we_i & (~bwp_i | all_smm);
    end else begin : g_no_bwp
      logic unused_in;
      assign unused_in = bwp_i ^ (^cpu_in_smm_i);
      assign ok_o      = we_i;
    end
  endgenerate
endmodule

// File: rtl/bios_wr_ctrl.sv
module bios_wr_ctrl
  import bios_wr_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CPUS    = 4,
  parameter bit          HAS_SMM_BWP = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic [NUM_CPUS-1:0] cpu_in_smm_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic                smi_req_o,
  output logic                flash_wr_ok_o
);
  ctl_state_t st;

  bios_wr_ctrl_regs #(.HAS_SMM_BWP(HAS_SMM_BWP)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .state_o  (st)
  );

  bios_wr_ctrl_trigger u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_we_i  (wr_data_i[WE_BIT]),
    .wr_lock_i(wr_data_i[LOCK_BIT]),
    .we_q_i   (st.we),
    .lock_q_i (st.lock),
    .smi_o    (smi_req_o)
  );

  bios_wr_ctrl_permit #(.NUM_CPUS(NUM_CPUS), .HAS_SMM_BWP(HAS_SMM_BWP)) u_permit (
    .we_i        (st.we),
    .bwp_i       (st.bwp),
    .cpu_in_smm_i(cpu_in_smm_i),
    .ok_o        (flash_wr_ok_o)
  );

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[WE_BIT]         = st.we;
    rd_data_o[LOCK_BIT]       = st.lock;
    rd_data_o[SCR_HI:SCR_LO]  = st.scr;
    rd_data_o[BWP_BIT]        = st.bwp;
  end
endmodule

// File: rtl/bios_wr_ctrl_chk.sv
module bios_wr_ctrl_chk #(
  parameter int unsigned NUM_CPUS    = 4,
  parameter bit          HAS_SMM_BWP = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [7:0]          wr_data_i,
  input logic [NUM_CPUS-1:0] cpu_in_smm_i,
  input logic [7:0]          rd_data_o,
  input logic                smi_req_o,
  input logic                flash_wr_ok_o
);
  assert_we_follows_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[0] == $past(wr_data_i[0]));

  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1] |=> rd_data_o[1]);

  assert_smi_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && !rd_data_o[0] && (rd_data_o[1] || wr_data_i[1])) |=> smi_req_o);

  assert_smi_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |=> !smi_req_o);

  assert_smi_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> (rd_data_o[0] && rd_data_o[1]));

  assert_no_smi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || !wr_data_i[0] || rd_data_o[0]) |=> !smi_req_o);

  assert_ok_needs_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_wr_ok_o == (rd_data_o[0] && (!rd_data_o[5] || (&cpu_in_smm_i))));

  assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00);

  generate
    if (!HAS_SMM_BWP) begin : g_nb
      assert_no_bwp_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_data_o[5]);
    end
  endgenerate
endmodule

bind bios_wr_ctrl bios_wr_ctrl_chk #(.NUM_CPUS(NUM_CPUS), .HAS_SMM_BWP(HAS_SMM_BWP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .cpu_in_smm_i (cpu_in_smm_i),
  .rd_data_o    (rd_data_o),
  .smi_req_o    (smi_req_o),
  .flash_wr_ok_o(flash_wr_ok_o)
);

// File: tb/bios_wr_ctrl_test.sv
module bios_wr_ctrl_test;
  localparam int unsigned NC = 4;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [NC-1:0] smm = '0;
  logic [7:0]    rd_a, rd_b;
  logic          smi_a, smi_b, ok_a, ok_b;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bios_wr_ctrl #(.NUM_CPUS(NC), .HAS_SMM_BWP(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cpu_in_smm_i(smm), .rd_data_o(rd_a), .smi_req_o(smi_a), .flash_wr_ok_o(ok_a));

  bios_wr_ctrl #(.NUM_CPUS(NC), .HAS_SMM_BWP(1'b0)) uut_nb (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cpu_in_smm_i(smm), .rd_data_o(rd_b), .smi_req_o(smi_b), .flash_wr_ok_o(ok_b));

  // {wr_data, smm, exp_rd, exp_smi, exp_ok} for the full-featured build
  typedef struct packed {
    logic [7:0] d;
    logic [3:0] s;
    logic [7:0] rd;
    logic       smi;
    logic       ok;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'h01, 4'h0, 8'h01, 1'b0, 1'b1},
    '{8'h00, 4'h0, 8'h00, 1'b0, 1'b0},
    '{8'h1C, 4'h0, 8'h1C, 1'b0, 1'b0},
    '{8'hC0, 4'h0, 8'h00, 1'b0, 1'b0},
    '{8'h20, 4'h0, 8'h20, 1'b0, 1'b0},
    '{8'h21, 4'h0, 8'h21, 1'b0, 1'b0},
    '{8'h21, 4'hF, 8'h21, 1'b0, 1'b1},
    '{8'h21, 4'h7, 8'h21, 1'b0, 1'b0},
    '{8'h00, 4'h0, 8'h00, 1'b0, 1'b0},
    '{8'h02, 4'h0, 8'h02, 1'b0, 1'b0},
    '{8'h0B, 4'h0, 8'h0B, 1'b1, 1'b1},
    '{8'h0B, 4'h0, 8'h0B, 1'b0, 1'b1},
    '{8'h08, 4'h0, 8'h0A, 1'b0, 1'b0},
    '{8'h0B, 4'h0, 8'h0B, 1'b1, 1'b1},
    '{8'h2B, 4'h0, 8'h2B, 1'b0, 1'b0},
    '{8'h0A, 4'hF, 8'h0A, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic [NC-1:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; smm = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd", rd_a, 8'h00);
    chk("R1 smi/ok", {6'b0, smi_a, ok_a}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk; both builds checked against the same stimulus
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].d, VEC[i].s);
      chk("R2 R3 R8 rd", rd_a, VEC[i].rd);
      chk("R4 R5 smi", {7'b0, smi_a}, {7'b0, VEC[i].smi});
      chk("R6 R7 ok", {7'b0, ok_a}, {7'b0, VEC[i].ok});
      chk("R9 rd", rd_b, VEC[i].rd & 8'h1F);
      chk("R9 ok", {7'b0, ok_b}, {7'b0, VEC[i].rd[0]});
      chk("R9 smi", {7'b0, smi_b}, {7'b0, VEC[i].smi});
      @(negedge clk);
      chk("R4 pulse ends", {7'b0, smi_a}, 8'h00);
    end

    // reset clears lock
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 R3 rd after reset", rd_a, 8'h00);
    rst_n = 1'b1;
    do_write(8'h01, '0);
    chk("R5 no smi unlocked", {7'b0, smi_a}, 8'h00);
    do_write(8'h00, '0);

    // lock and enable in one write, then handler reverts
    do_write(8'h03, '0);
    chk("R4 same-write lock smi", {7'b0, smi_a}, 8'h01);
    chk("R4 rd", rd_a, 8'h03);
    repeat (3) begin
      @(negedge clk);
      chk("R10 ok before revert", {7'b0, ok_a}, 8'h01);
    end
    do_write(8'h02, '0);
    chk("R10 ok dropped", {7'b0, ok_a}, 8'h00);
    chk("R10 lock kept", rd_a, 8'h02);
    chk("R10 no smi on clear", {7'b0, smi_a}, 8'h00);

    // smm status changes without write affect permission combinationally
    do_write(8'h21, 4'hF);
    chk("R7 all smm", {7'b0, ok_a}, 8'h01);
    smm = 4'hE;
    #1;
    chk("R7 one cpu out", {7'b0, ok_a}, 8'h00);
    chk("R9 ignores smm", {7'b0, ok_b}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule